// File: doc/BRIEF.md
# Ancillary Data Mailbox

This block is a one-frame mailbox between a stream decoder and a host microcontroller. The decoder pushes up to 56 bytes of optional per-frame user data, one byte per cycle with an explicit slot index. It then marks the end of the frame and supplies the number of valid bits in it. From that point the mailbox is locked. The host sees the data bytes, the bit count, a ready flag and an error code through a small register port that it polls.

The host reads the bytes and the count, then writes 1 to bit 0 of the status register. That write unlocks the mailbox for the next frame. If the decoder completes another frame while the mailbox is still locked, that frame is thrown away and an error code is raised. The host therefore always reads one coherent frame and learns that it missed one.

The control is a two-state machine. OPEN accepts byte writes. HELD holds the data frozen for the host. Three transitions exist. DELIVER goes from OPEN to HELD on an end-of-frame. RELEASE goes from HELD to OPEN on a host clear. OVERRUN is the self-loop in HELD on an end-of-frame, and it records the error.

Top module: `anc_mailbox`

## Requirements
- R1: After reset the status, error, count-low and count-high registers and every data byte read as 0x00.
- R2: In OPEN, a byte write with index below 56 stores the byte so that it reads back at host address 0x7E plus the index, and a later write to the same index replaces it.
- R3: A byte write with index 56 to 63 changes no data register.
- R4: An end-of-frame in OPEN takes the machine to HELD (DELIVER). Status bit 0 then reads 1, the count-low address 0x60 reads frame_bits[7:0] and the count-high address 0x61 reads frame_bits[15:8].
- R5: In HELD, byte writes change no data register and the count stays unchanged.
- R6: An end-of-frame in HELD (OVERRUN) sets the error register at 0x11 to 0x01. The frame's bytes and bit count are discarded.
- R7: A host write to the status address 0x10 with bit 0 set returns the machine to OPEN (RELEASE), and status bit 0 reads 0. A write with bit 0 clear has no effect.
- R8: The error code holds until the host writes 0x00 to 0x11. Nonzero writes to it have no effect.
- R9: Reads of any address outside 0x10, 0x11, 0x60, 0x61 and 0x7E to 0xB5 return 0x00, and status bits 7 to 1 read 0.
- R10: host_rdata shows the register selected by host_addr starting at the clock edge after host_addr is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer byte write strobe |
| wr_index | input | 6 | Slot index of the byte |
| wr_data | input | 8 | Byte value |
| frame_done | input | 1 | End-of-frame strobe |
| frame_bits | input | 16 | Number of valid ancillary bits in the frame |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |

## Verification
The assertions check the following on every cycle:
- the DELIVER transition and the count it captures;
- the frozen count in HELD;
- the error code raised by OVERRUN and its retention;
- RELEASE on a host clear;
- the one-cycle read latency of the status register.

Only the bench scenarios can show that bytes land at the right address and stay frozen while the mailbox is locked. The same holds for out-of-range indices touching nothing, ineffective host writes and unmapped addresses reading zero. Each of these needs a full read-back through the host port.

// File: rtl/anc_pkg.sv
package anc_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } mb_state_t;

    localparam logic [7:0] ADDR_STATUS = 8'h10;
    localparam logic [7:0] ADDR_ERROR  = 8'h11;
    localparam logic [7:0] ADDR_CNT_LO = 8'h60;
    localparam logic [7:0] ADDR_CNT_HI = 8'h61;
    localparam logic [7:0] ADDR_DATA0  = 8'h7E;
    localparam logic [7:0] ERR_OVERRUN = 8'h01;
endpackage

// File: rtl/anc_store.sv
module anc_store #(
    parameter int DEPTH  = 56,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i*DATA_W +: DATA_W] <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                q[i*DATA_W +: DATA_W] <= din;
            end
        end
    end
endmodule

// File: rtl/anc_ctrl.sv
module anc_ctrl
    import anc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] frame_bits,
    input  logic             clr_req,
    input  logic             err_clr_req,
    output logic             held,
    output logic             accept,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [ERR_W-1:0] err_code
);
    mb_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: if (frame_done) state_nx = ST_HELD;
            ST_HELD: if (clr_req)    state_nx = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            err_code <= '0;
        end else begin
            unique case (state)
                ST_OPEN: begin
                    if (frame_done) bit_cnt <= frame_bits;
                    if (err_clr_req) err_code <= '0;
                end
                ST_HELD: begin
                    if (frame_done)       err_code <= ERR_W'(ERR_OVERRUN);
                    else if (err_clr_req) err_code <= '0;
                end
            endcase
        end
    end

    assign held   = (state == ST_HELD);
    assign accept = (state == ST_OPEN);
endmodule

// File: rtl/anc_readmux.sv
module anc_readmux
    import anc_pkg::*;
#(
    parameter int DEPTH  = 56,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int AW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [DEPTH*DATA_W-1:0] data_flat,
    input  logic                    held,
    input  logic [CNT_W-1:0]        bit_cnt,
    input  logic [DATA_W-1:0]       err_code,
    output logic [DATA_W-1:0]       rdata
);
    localparam int BASE = int'(ADDR_DATA0);
    localparam int LAST = BASE + DEPTH - 1;

    logic [DATA_W-1:0] rd_nx;
    int                a_int;

    always_comb begin
        a_int = int'(addr);
        rd_nx = '0;
        if (a_int >= BASE && a_int <= LAST) begin
            rd_nx = data_flat[(a_int - BASE)*DATA_W +: DATA_W];
        end else if (addr == AW'(ADDR_STATUS)) begin
            rd_nx = DATA_W'(held);
        end else if (addr == AW'(ADDR_ERROR)) begin
            rd_nx = err_code;
        end else if (addr == AW'(ADDR_CNT_LO)) begin
            rd_nx = bit_cnt[DATA_W-1:0];
        end else if (addr == AW'(ADDR_CNT_HI)) begin
            rd_nx = bit_cnt[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_nx;
    end
endmodule

// File: rtl/anc_mailbox.sv
module anc_mailbox
    import anc_pkg::*;
#(
    parameter int DEPTH  = 56,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_done,
    input  logic [CNT_W-1:0]  frame_bits,
    input  logic [AW-1:0]     host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic                    held;
    logic                    accept;
    logic [CNT_W-1:0]        bit_cnt;
    logic [DATA_W-1:0]       err_code;
    logic [DEPTH*DATA_W-1:0] data_flat;
    logic                    clr_req;
    logic                    err_clr_req;

    assign clr_req     = host_wr && host_addr == AW'(ADDR_STATUS) && host_wdata[0];
    assign err_clr_req = host_wr && host_addr == AW'(ADDR_ERROR) && host_wdata == '0;

    anc_ctrl #(.CNT_W(CNT_W), .ERR_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_bits(frame_bits),
        .clr_req(clr_req), .err_clr_req(err_clr_req), .held(held), .accept(accept),
        .bit_cnt(bit_cnt), .err_code(err_code)
    );

    anc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_valid && accept), .idx(wr_index),
        .din(wr_data), .q(data_flat)
    );

    anc_readmux #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(host_addr), .data_flat(data_flat),
        .held(held), .bit_cnt(bit_cnt), .err_code(err_code), .rdata(host_rdata)
    );
endmodule

// File: rtl/anc_mailbox_chk.sv
module anc_mailbox_chk
    import anc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic [CNT_W-1:0]  frame_bits,
    input logic [AW-1:0]     host_addr,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              held,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] err_code
);
    logic clr_w, errclr_w;
    assign clr_w    = host_wr && host_addr == AW'(ADDR_STATUS) && host_wdata[0];
    assign errclr_w = host_wr && host_addr == AW'(ADDR_ERROR) && host_wdata == '0;

    AST_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && frame_done) |=> (held && bit_cnt == $past(frame_bits))); // R4
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(bit_cnt)); // R5
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && frame_done) |=> (err_code == DATA_W'(ERR_OVERRUN))); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr_w) |=> !held); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != '0 && !errclr_w) |=> (err_code == $past(err_code))); // R8
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_addr) == AW'(ADDR_STATUS)) |-> (host_rdata == DATA_W'($past(held)))); // R10
endmodule

bind anc_mailbox anc_mailbox_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_bits(frame_bits),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .held(held), .bit_cnt(bit_cnt), .err_code(err_code)
);

// File: tb/anc_mailbox_test.sv
`timescale 1ns/1ps
module anc_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [7:0]  wr_data = '0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_bits = '0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  m_data [56];
    logic [15:0] m_cnt;
    logic        m_flag;
    logic [7:0]  m_err;

    always #2.5 clk = ~clk;

    anc_mailbox uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_data(wr_data), .frame_done(frame_done), .frame_bits(frame_bits),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a >= 8'h7E && a <= 8'hB5) return m_data[a - 8'h7E];
        if (a == 8'h10) return {7'b0, m_flag};
        if (a == 8'h11) return m_err;
        if (a == 8'h60) return m_cnt[7:0];
        if (a == 8'h61) return m_cnt[15:8];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_wr = 1'b0;
        @(negedge clk); d = host_rdata;
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        logic [7:0] d;
        host_read(a, d);
        check(req, d, exp_read(a));
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        if (a == 8'h10 && d[0]) m_flag = 1'b0;
        if (a == 8'h11 && d == 8'h00) m_err = 8'h00;
    endtask

    task automatic push(input logic [5:0] idx, input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_index = idx; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
        if (!m_flag && idx < 6'd56) m_data[idx] = d;
    endtask

    task automatic end_frame(input logic [15:0] bits);
        @(negedge clk); frame_done = 1'b1; frame_bits = bits;
        @(negedge clk); frame_done = 1'b0;
        if (!m_flag) begin m_cnt = bits; m_flag = 1'b1; end
        else m_err = 8'h01;
    endtask

    task automatic verify_all(input string req);
        for (int i = 0; i < 56; i++) read_check(req, 8'h7E + 8'(i));
        read_check(req, 8'h60);
        read_check(req, 8'h61);
        read_check(req, 8'h10);
        read_check(req, 8'h11);
    endtask

    task automatic random_frame(input int n, input bit with_high);
        for (int k = 0; k < n; k++) begin
            if (with_high && ($urandom % 4 == 0)) push(6'(56 + $urandom % 8), 8'($urandom));
            else push(6'($urandom % 56), 8'($urandom));
        end
        end_frame(16'($urandom));
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 56; i++) m_data[i] = 8'h00;
        m_cnt = '0; m_flag = 1'b0; m_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        verify_all("R1");

        // R2 R4: fill slots 0 and 55, then a random frame
        push(6'd0, 8'hA5);
        push(6'd55, 8'h5A);
        push(6'd0, 8'h3C);
        random_frame(40, 1'b0);
        verify_all("R2/R4");

        // R5 R6: writes and end-of-frame while held
        for (int k = 0; k < 20; k++) push(6'($urandom % 56), 8'($urandom));
        verify_all("R5");
        end_frame(16'hBEEF);
        verify_all("R6");

        // R7: writing 0 to status is ignored, writing 1 releases
        host_write(8'h10, 8'hFE);
        read_check("R7", 8'h10);
        host_write(8'h10, 8'h01);
        read_check("R7", 8'h10);

        // R8: a nonzero write keeps the error, a zero write clears it
        host_write(8'h11, 8'h05);
        read_check("R8", 8'h11);
        host_write(8'h11, 8'h00);
        read_check("R8", 8'h11);

        // R3: indices 56..63 leave every slot alone
        for (int k = 56; k < 64; k++) push(6'(k), 8'hFF);
        verify_all("R3");

        // R9: unmapped addresses
        read_check("R9", 8'h00);
        read_check("R9", 8'h7D);
        read_check("R9", 8'hB6);
        read_check("R9", 8'hFF);
        read_check("R9", 8'h12);

        // Random rounds mixing all behaviours
        for (int r = 0; r < 6; r++) begin
            random_frame(10 + int'($urandom % 30), 1'b1);
            verify_all("R2/R4");
            if ($urandom % 2 == 1) begin
                random_frame(5, 1'b1);
                verify_all("R6");
                host_write(8'h11, 8'h00);
            end
            host_write(8'h10, 8'h01);
            read_check("R7", 8'h10);
        end

        // R10: the value changes only after the edge
        end_frame(16'h0123);
        host_read(8'h10, d);
        check("R10", d, 8'h01);
        @(negedge clk); host_addr = 8'h00;
        #1 check("R10", host_rdata, 8'h01);
        @(negedge clk);
        check("R10", host_rdata, 8'h00);

        finish_up();
    end
endmodule